// File: doc/BRIEF.md
# Pipelined SRAM Control with Selectable Deselect Timing

This block is the synchronous front end and data path of a pipelined-read static RAM. The rising clock edge captures each command, made of an address, a chip select, the write controls and the write data. Writes land in a behavioural array one edge later, either on a chosen set of 9-bit byte lanes or on all of them. A read is answered from an output register one clock after the command is captured. An external address sequencer is expected to present a new address on every cycle.

The enable of the data bus is pipelined. A mode input chooses how quickly a deselect shuts the bus off. In the early (single-cycle) mode, a deselect cuts the bus as soon as it is captured, which is one stage ahead of the read data. In the late (dual-cycle) mode, a deselect travels the full read depth, so the last read word is still driven for one cycle. An active-low output enable and an active-high sleep input gate the bus at once, with no clock involved. A command captured while sleep is high is treated as a deselect, so the array keeps its contents.

Top module: `psram_ctrl`

## Requirements
- R1: All command inputs are captured on the rising clock edge. A synchronous active-low reset empties the command and data pipelines, and bus_oe is 0 after reset until a read reaches the data stage.
- R2: A read captured at edge k loads dout with the stored word at edge k+1. bus_oe then rises after edge k+1, provided the deselect rules allow it.
- R3: With dual_dsel=0, a deselect (cs=0) captured at edge k+1 forces bus_oe to 0 right after that edge, even when a read captured at edge k is in the data stage. A write captured at edge k+1 does not cut the bus.
- R4: With dual_dsel=1, a deselect captured at edge k+1 does not cut the read captured at edge k. The bus turns off only after the following edge.
- R5: dual_dsel is read combinationally against the current pipeline state. Changing it mid-cycle changes bus_oe without waiting for a clock edge.
- R6: A write with lane_wen=1 and wr_all=0 stores din[9i+8:9i] only for the lanes i whose lane_sel[i] is 1. The other lanes keep their old contents.
- R7: wr_all=1 writes all eight lanes, whatever lane_wen and lane_sel hold.
- R8: lane_wen=1 with lane_sel all zero is a write that changes nothing in the array.
- R9: A write never drives the bus: bus_oe is 0 while a write is in the data stage.
- R10: A read of an address returns the latest data written there, including when the read is issued in the cycle right after the write.
- R11: oe_n=1 forces bus_oe to 0 at once, and releasing it restores the pipelined value in the same cycle.
- R12: sleep=1 forces bus_oe to 0 at once. A command captured while sleep=1 is treated as a deselect, so array contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_dsel | input | 1 | 0: early deselect, 1: deselect at read depth |
| cs | input | 1 | Chip select, high to issue a command |
| lane_wen | input | 1 | Byte-lane write enable |
| lane_sel | input | 8 | Per-lane write strobes |
| wr_all | input | 1 | Global write of all lanes |
| addr | input | ADDR_W | Word address |
| din | input | 72 | Write data, eight 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| dout | output | 72 | Registered read data |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
Most internal faults in this block surface at bus_oe within one or two clocks. A data-stage flag that keeps the wrong state shows up on the first cycle after a read, after a deselect, or after a write. A deselect wired to the wrong pipeline depth shows up in the single cycle that follows a read ended by a deselect, and it differs between the two modes. A lane-mask fault shows only in the word read back two cycles after the write, and only in the lanes that were left unstrobed.

// File: rtl/psram_pkg.sv
// Shared lane geometry and the command type carried down the pipeline.
// Assumes an 8-lane, 9-bit-per-lane data word.
package psram_pkg;
    parameter int unsigned NLANE  = 8;
    parameter int unsigned LANE_W = 9;
    localparam int unsigned WORD_W = NLANE * LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_t;
endpackage

// File: rtl/psram_cmd_reg.sv
// Input capture stage: classifies each clocked command and registers it.
// Assumes the address arrives already sequenced; sleep is sampled as a deselect.
module psram_cmd_reg
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              lane_wen,
    input  logic [NLANE-1:0]  lane_sel,
    input  logic              wr_all,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output op_t               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NLANE-1:0]  mask_q,
    output logic [WORD_W-1:0] data_q
);
    op_t              op_d;
    logic [NLANE-1:0] mask_d;

    // Decode the command type and the lane mask from the raw controls.
    always_comb begin
        if (!cs || sleep)
            op_d = OP_IDLE;
        else if (wr_all || lane_wen)
            op_d = OP_WRITE;
        else
            op_d = OP_READ;
        if (wr_all)
            mask_d = '1;
        else if (lane_wen)
            mask_d = lane_sel;
        else
            mask_d = '0;
    end

    // Register the decoded command on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            mask_q <= '0;
            data_q <= '0;
        end else begin
            op_q   <= op_d;
            addr_q <= addr;
            mask_q <= mask_d;
            data_q <= din;
        end
    end
endmodule

// File: rtl/psram_array.sv
// Behavioural storage, one memory per lane, with a registered read port.
// Assumes commands come from the capture stage; contents are not reset.
module psram_array
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  op_t               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLANE-1:0]  mask,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when strobed, or load its read register on a read.
        always_ff @(posedge clk) begin
            if (op == OP_WRITE && mask[g])
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (op == OP_READ)
                rdata[g*LANE_W +: LANE_W] <= mem[addr];
        end
    end
endmodule

// File: rtl/psram_oe_ctrl.sv
// Output-enable pipeline with early or read-depth deselect timing.
// Assumes op_s1 is the captured command; oe_n and sleep are asynchronous.
module psram_oe_ctrl
    import psram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_t  op_s1,
    input  logic dual_dsel,
    input  logic oe_n,
    input  logic sleep,
    output logic bus_oe
);
    logic rd_s2;
    logic wr_s2;
    logic pipe_en;

    // Advance the command type into the data stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_s2 <= 1'b0;
            wr_s2 <= 1'b0;
        end else begin
            rd_s2 <= (op_s1 == OP_READ);
            wr_s2 <= (op_s1 == OP_WRITE);
        end
    end

    // Combine data-stage read, deselect mode and the asynchronous gates.
    always_comb begin
        pipe_en = rd_s2 && (dual_dsel || op_s1 != OP_IDLE);
        bus_oe  = pipe_en && !oe_n && !sleep;
    end

    assert_write_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_s2 |-> !bus_oe);
    assert_early_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_dsel && op_s1 == OP_IDLE) |-> !bus_oe);
endmodule

// File: rtl/psram_ctrl.sv
// Top level: capture stage, lane array and bus enable pipeline.
// Assumes a 72-bit word in eight 9-bit lanes; burst sequencing is external.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_dsel,
    input  logic              cs,
    input  logic              lane_wen,
    input  logic [NLANE-1:0]  lane_sel,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [WORD_W-1:0] dout,
    output logic              bus_oe
);
    op_t               op_s1;
    logic [ADDR_W-1:0] addr_s1;
    logic [NLANE-1:0]  mask_s1;
    logic [WORD_W-1:0] data_s1;

    psram_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cs(cs), .lane_wen(lane_wen),
        .lane_sel(lane_sel), .wr_all(wr_all), .sleep(sleep), .addr(addr),
        .din(din), .op_q(op_s1), .addr_q(addr_s1), .mask_q(mask_s1),
        .data_q(data_s1)
    );

    psram_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .op(op_s1), .addr(addr_s1), .mask(mask_s1),
        .wdata(data_s1), .rdata(dout)
    );

    psram_oe_ctrl u_oe (
        .clk(clk), .rst_n(rst_n), .op_s1(op_s1), .dual_dsel(dual_dsel),
        .oe_n(oe_n), .sleep(sleep), .bus_oe(bus_oe)
    );

    assert_late_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_dsel && !oe_n && !sleep && $past(rst_n) && $past(op_s1) == OP_READ)
        |-> bus_oe);
    assert_sleep_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !bus_oe);
    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_oe);
endmodule

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;
    localparam int AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_dsel = 1'b0;
    logic        cs = 1'b0;
    logic        lane_wen = 1'b0;
    logic [7:0]  lane_sel = '0;
    logic        wr_all = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [71:0] din = '0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [71:0] dout;
    logic        bus_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psram_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .dual_dsel(dual_dsel), .cs(cs),
        .lane_wen(lane_wen), .lane_sel(lane_sel), .wr_all(wr_all),
        .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .bus_oe(bus_oe)
    );

    typedef struct packed {
        logic       dual;
        logic       sel;
        logic       wr;
        logic [7:0] a;
        logic [7:0] seed;
        logic       exp_oe;
        logic [7:0] exp_seed;
    } vec_t;

    // Global writes and reads; expectation is sampled after the vector's edge.
    localparam vec_t VECS [13] = '{
        '{1'b0, 1'b1, 1'b1, 8'd1, 8'd11, 1'b0, 8'd0},   // R1 idle data stage
        '{1'b0, 1'b1, 1'b1, 8'd2, 8'd22, 1'b0, 8'd0},   // R9 write silent
        '{1'b0, 1'b1, 1'b0, 8'd1, 8'd0,  1'b0, 8'd0},   // R9 write silent
        '{1'b0, 1'b1, 1'b0, 8'd2, 8'd0,  1'b1, 8'd11},  // R2 read a1
        '{1'b0, 1'b0, 1'b0, 8'd0, 8'd0,  1'b0, 8'd0},   // R3 early cut
        '{1'b1, 1'b1, 1'b0, 8'd1, 8'd0,  1'b0, 8'd0},   // R3 idle stage
        '{1'b1, 1'b0, 1'b0, 8'd0, 8'd0,  1'b1, 8'd11},  // R4 held
        '{1'b1, 1'b0, 1'b0, 8'd0, 8'd0,  1'b0, 8'd0},   // R4 off next
        '{1'b1, 1'b1, 1'b0, 8'd2, 8'd0,  1'b0, 8'd0},   // R1 idle
        '{1'b1, 1'b1, 1'b1, 8'd2, 8'd33, 1'b1, 8'd22},  // R2 read a2
        '{1'b1, 1'b1, 1'b0, 8'd2, 8'd0,  1'b0, 8'd0},   // R9 write silent
        '{1'b0, 1'b1, 1'b0, 8'd1, 8'd0,  1'b1, 8'd33},  // R10 new data
        '{1'b0, 1'b0, 1'b0, 8'd0, 8'd0,  1'b0, 8'd0}    // R3 early cut
    };

    function automatic logic [71:0] dpat(input int s);
        logic [71:0] r;
        for (int i = 0; i < 8; i++)
            r[i*9 +: 9] = 9'((s * 53 + i * 29 + 7) % 512);
        return r;
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic lw, input logic [7:0] ls,
                        input logic wa, input logic [AW-1:0] a, input int seed);
        cs = c; lane_wen = lw; lane_sel = ls; wr_all = wa; addr = a; din = dpat(seed);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [71:0] merged;
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        chk("R1 reset bus off", 72'(bus_oe), 72'd0);

        for (int i = 0; i < 13; i++) begin
            dual_dsel = VECS[i].dual;
            step(VECS[i].sel, 0, 0, VECS[i].wr, VECS[i].a, int'(VECS[i].seed));
            chk($sformatf("R2/R3/R4/R9/R10 vec %0d oe", i), 72'(bus_oe), 72'(VECS[i].exp_oe));
            if (VECS[i].exp_oe)
                chk($sformatf("R2/R10 vec %0d data", i), dout, dpat(int'(VECS[i].exp_seed)));
        end

        // R6: lane-masked write over a global write
        dual_dsel = 1'b1;
        step(1, 0, 0, 1, 5, 40);
        step(1, 1, 8'hA5, 0, 5, 41);
        step(1, 0, 0, 0, 5, 0);
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++)
            merged[i*9 +: 9] = (8'hA5 >> i) & 1 ? dpat(41) >> (i*9) : dpat(40) >> (i*9);
        chk("R6 lane merge oe", 72'(bus_oe), 72'd1);
        chk("R6 lane merge data", dout, merged);

        // R8: enable with no strobes writes nothing and drives nothing
        step(1, 1, 8'h00, 0, 5, 50);
        step(1, 0, 0, 0, 5, 0);
        chk("R8 empty write silent", 72'(bus_oe), 72'd0);
        step(0, 0, 0, 0, 0, 0);
        chk("R8 empty write no change", dout, merged);

        // R7: global write ignores lane controls
        step(1, 1, 8'h00, 1, 6, 60);
        step(1, 0, 0, 0, 6, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 global override", dout, dpat(60));

        // R11 and R12: asynchronous gating
        step(1, 0, 0, 0, 6, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R11 base on", 72'(bus_oe), 72'd1);
        oe_n = 1'b1; #1;
        chk("R11 oe_n off", 72'(bus_oe), 72'd0);
        oe_n = 1'b0; #1;
        chk("R11 oe_n restore", 72'(bus_oe), 72'd1);
        sleep = 1'b1; #1;
        chk("R12 sleep off", 72'(bus_oe), 72'd0);
        step(1, 0, 0, 1, 6, 70);
        sleep = 1'b0;
        step(1, 0, 0, 0, 6, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R12 sleep write ignored", dout, dpat(60));

        // R5: mode change acts within the cycle
        step(1, 0, 0, 0, 6, 0);
        dual_dsel = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        chk("R5 early mode off", 72'(bus_oe), 72'd0);
        dual_dsel = 1'b1; #1;
        chk("R5 late mode on", 72'(bus_oe), 72'd1);

        // R1: mid-run reset clears the data stage
        step(1, 0, 0, 0, 6, 0);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        chk("R1 reset clears", 72'(bus_oe), 72'd0);

        summary();
    end
endmodule